// File: doc/BRIEF.md
# Serial Flash Boot Loader

This block brings a processor out of reset by loading its program from a standard serial flash into RAM. After reset it holds the CPU in reset. It drops the flash select line for one cycle and then raises it. It then sends the serial-flash read command and a three-byte start address, most significant byte first. After that it reads image bytes one at a time. Each byte goes to the next RAM byte address, starting at the RAM base.

The length of the image is carried by the image itself. The first four bytes read form a big-endian byte count, with the first byte received as bits [31:24]. From the fourth byte on, that count is the point at which the copy stops. Until then the stop point is held at 0xFFFF0000, so the copy cannot end early. When the copy ends, the loader releases the flash select line. It then presents the jump address (RAM base OR 0x100), raises `boot_done` and releases the CPU reset.

An optional plausibility check can be enabled. With it, a byte count whose upper halfword is greater than a set limit makes the loader start the whole sequence again. Bit-level serial shifting is not part of this block. The loader drives a byte-exchange engine through a start pulse and a transmit byte. It takes the received byte when the engine reports done.

Top module: `spi_boot_loader`

## Requirements
- R1: While reset is applied and after it is released, `cpu_reset` is 1, `boot_done` is 0, `jump_addr` is 0 and no RAM write occurs until image bytes arrive.
- R2: Before the first exchange of each boot attempt, `spi_sel` is 0 for at least one cycle and then goes to 1. Every `spi_start` pulse and every RAM write happens while `spi_sel` is 1.
- R3: The first byte sent in each attempt is the read opcode 0x03.
- R4: Bytes two to four are the flash start address, most significant first, taken from parameters (default 0x0C, 0x00, 0x00).
- R5: Every image byte is fetched by sending the dummy byte 0x00. A new `spi_start` pulse is issued only after the previous exchange has reported `spi_done`. `spi_done` in the start cycle is ignored.
- R6: The n-th image byte (n from 0) is written with a one-cycle `ram_we` to address RAM base + n. The data is the byte received.
- R7: Image bytes 0..3 form the size word S, big-endian. When S > 4, exactly S image bytes are read and written. This makes 4 + S exchanges per attempt.
- R8: When S <= 4, the copy ends right after the fourth image byte, with no further exchange.
- R9: On completion, `spi_sel` goes to 0, `boot_done` goes to 1, `cpu_reset` goes to 0 and `jump_addr` equals RAM base OR 0x100. These values hold with no further exchange until the next reset.
- R10: With the check enabled, a size word whose bits [31:16] exceed 0x0200 makes the loader deselect the flash and restart from the opcode. The new attempt writes again from RAM base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_start | output | 1 | One-cycle request to exchange one byte |
| spi_tx | output | 8 | Byte to send, valid with `spi_start` |
| spi_done | input | 1 | Exchange finished, received byte valid |
| spi_rx | input | 8 | Byte received in the exchange |
| spi_sel | output | 1 | Flash select line 0, active high |
| ram_we | output | 1 | One-cycle RAM byte write strobe |
| ram_addr | output | 32 | RAM byte address |
| ram_data | output | 8 | RAM write data |
| cpu_reset | output | 1 | Holds the CPU in reset while high |
| boot_done | output | 1 | Image loaded, jump address valid |
| jump_addr | output | 32 | Address the CPU starts from |

## Verification
A wrong byte counter shows up at the RAM port on the very next write, as a skipped or repeated address. It also shows up at completion, as a wrong number of exchanges. A badly assembled size word or stop point does not show up until the end of the copy. There it appears as a copy that ends early or runs on, and only the total exchange count reveals it. A stuck exchange handshake shows within one byte time, as a second `spi_start` without a `spi_done` or as a stall. A failed restart shows one exchange after the header, as a missing deselect pulse.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  typedef enum logic [3:0] {
    PH_DESEL,
    PH_SEL,
    PH_CMD,
    PH_ADR2,
    PH_ADR1,
    PH_ADR0,
    PH_COPY,
    PH_DONE
  } boot_phase_e;

  localparam logic [31:0] PRE_LIMIT   = 32'hFFFF_0000;
  localparam logic [7:0]  READ_OPCODE = 8'h03;
  localparam int          HDR_BYTES   = 4;

  // Shift a newly received byte into the low end of a big-endian word.
  function automatic logic [31:0] push_be(input logic [31:0] w, input logic [7:0] b);
    return {w[23:0], b};
  endfunction

  // Upper halfword compared against the plausible maximum.
  function automatic logic size_is_insane(input logic [31:0] sw, input logic [15:0] max_hi);
    return sw[31:16] > max_hi;
  endfunction

  // Copy is over once the byte count reaches the limit (or a limit at or below it).
  function automatic logic copy_complete(input logic [31:0] n, input logic [31:0] lim);
    return n >= lim;
  endfunction

  function automatic logic [31:0] jump_target(input logic [31:0] base, input logic [31:0] ofs);
    return base | ofs;
  endfunction

endpackage

// File: rtl/spi_xfer_ctl.sv
module spi_xfer_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] tx_in,
  output logic          spi_start,
  output logic [DW-1:0] spi_tx,
  input  logic          spi_done,
  input  logic [DW-1:0] spi_rx,
  output logic          busy,
  output logic          fin,
  output logic [DW-1:0] rx_out
);

  logic accept_done;
  assign accept_done = busy && !spi_start && spi_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      spi_start <= 1'b0;
      spi_tx    <= '0;
      fin       <= 1'b0;
      rx_out    <= '0;
    end else begin
      spi_start <= 1'b0;
      fin       <= 1'b0;
      if (!busy && go) begin
        busy      <= 1'b1;
        spi_start <= 1'b1;
        spi_tx    <= tx_in;
      end else if (accept_done) begin
        busy   <= 1'b0;
        fin    <= 1'b1;
        rx_out <= spi_rx;
      end
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start); // R5
  AST_FIN_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy && !spi_start); // R5
  AST_NO_START_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !spi_start) |=> !spi_start); // R5

endmodule

// File: rtl/size_tracker.sv
module size_tracker
  import spi_boot_pkg::*;
#(
  parameter int          CW        = 32,
  parameter bit          SANITY_EN = 1'b1,
  parameter logic [15:0] MAX_HI    = 16'h0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          byte_en,
  input  logic [7:0]    byte_in,
  output logic [CW-1:0] count_q,
  output logic          at_end,
  output logic          insane
);

  logic [31:0]   shift_q;
  logic [31:0]   limit_q;
  logic [CW-1:0] cnt_nxt;
  logic [31:0]   assembled;
  logic          hdr_now;
  logic [31:0]   eff_limit;

  assign cnt_nxt   = count_q + 1'b1;
  assign assembled = push_be(shift_q, byte_in);
  assign hdr_now   = (cnt_nxt == CW'(HDR_BYTES));
  assign eff_limit = hdr_now ? assembled : limit_q;
  assign at_end    = byte_en && copy_complete(32'(cnt_nxt), eff_limit);
  assign insane    = byte_en && hdr_now && SANITY_EN && size_is_insane(assembled, MAX_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      shift_q <= '0;
      limit_q <= PRE_LIMIT;
    end else if (clear) begin
      count_q <= '0;
      shift_q <= '0;
      limit_q <= PRE_LIMIT;
    end else if (byte_en) begin
      count_q <= cnt_nxt;
      if (count_q < CW'(HDR_BYTES)) shift_q <= assembled;
      if (hdr_now) limit_q <= assembled;
    end
  end

  AST_LIMIT_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q < CW'(HDR_BYTES)) |-> limit_q == PRE_LIMIT); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && !clear) |=> count_q == $past(count_q) + 1'b1); // R6
  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && count_q < CW'(HDR_BYTES - 1)) |-> !at_end); // R8

endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
  import spi_boot_pkg::*;
#(
  parameter int          AW        = 32,
  parameter logic [7:0]  ADR_HI    = 8'h0C,
  parameter logic [7:0]  ADR_MID   = 8'h00,
  parameter logic [7:0]  ADR_LO    = 8'h00,
  parameter logic [7:0]  DUMMY     = 8'h00,
  parameter logic [31:0] RAM_BASE  = 32'h0,
  parameter logic [31:0] RESET_OFS = 32'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          fin,
  input  logic [7:0]    rx_byte,
  input  logic [AW-1:0] count_q,
  input  logic          at_end,
  input  logic          insane,
  output logic          go,
  output logic [7:0]    tx_byte,
  output logic          byte_en,
  output logic          clear,
  output logic          spi_sel,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_data,
  output logic          boot_done,
  output logic [31:0]   jump_addr
);

  boot_phase_e phase_q;
  logic        pend_q;
  logic        xfer_phase;

  assign xfer_phase = (phase_q == PH_CMD) || (phase_q == PH_ADR2) ||
                      (phase_q == PH_ADR1) || (phase_q == PH_ADR0) ||
                      (phase_q == PH_COPY);
  assign go      = xfer_phase && !busy && !pend_q;
  assign byte_en = fin && (phase_q == PH_COPY);
  assign clear   = (phase_q == PH_DESEL);

  always_comb begin
    case (phase_q)
      PH_CMD:  tx_byte = READ_OPCODE;
      PH_ADR2: tx_byte = ADR_HI;
      PH_ADR1: tx_byte = ADR_MID;
      PH_ADR0: tx_byte = ADR_LO;
      default: tx_byte = DUMMY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_DESEL;
      pend_q    <= 1'b0;
      spi_sel   <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_data  <= '0;
      boot_done <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      if (go) pend_q <= 1'b1;
      else if (fin) pend_q <= 1'b0;
      case (phase_q)
        PH_DESEL: begin
          spi_sel <= 1'b0;
          phase_q <= PH_SEL;
        end
        PH_SEL: begin
          spi_sel <= 1'b1;
          phase_q <= PH_CMD;
        end
        PH_CMD:  if (fin) phase_q <= PH_ADR2;
        PH_ADR2: if (fin) phase_q <= PH_ADR1;
        PH_ADR1: if (fin) phase_q <= PH_ADR0;
        PH_ADR0: if (fin) phase_q <= PH_COPY;
        PH_COPY: begin
          if (fin) begin
            ram_we   <= 1'b1;
            ram_addr <= AW'(RAM_BASE) + count_q;
            ram_data <= rx_byte;
            if (insane)      phase_q <= PH_DESEL;
            else if (at_end) phase_q <= PH_DONE;
          end
        end
        PH_DONE: begin
          spi_sel   <= 1'b0;
          boot_done <= 1'b1;
        end
        default: phase_q <= PH_DESEL;
      endcase
    end
  end

  assign jump_addr = boot_done ? jump_target(RAM_BASE, RESET_OFS) : 32'h0;

  AST_WE_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> spi_sel); // R2
  AST_GO_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> spi_sel); // R2
  AST_DONE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !spi_sel && !go); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done && $stable(jump_addr)); // R9
  AST_RESTART_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && insane) |=> ##1 !spi_sel); // R10

endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import spi_boot_pkg::*;
#(
  parameter int          AW        = 32,
  parameter logic [7:0]  ADR_HI    = 8'h0C,
  parameter logic [7:0]  ADR_MID   = 8'h00,
  parameter logic [7:0]  ADR_LO    = 8'h00,
  parameter logic [7:0]  DUMMY     = 8'h00,
  parameter logic [31:0] RAM_BASE  = 32'h0,
  parameter logic [31:0] RESET_OFS = 32'h100,
  parameter bit          SANITY_EN = 1'b1,
  parameter logic [15:0] MAX_HI    = 16'h0200
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          spi_start,
  output logic [7:0]    spi_tx,
  input  logic          spi_done,
  input  logic [7:0]    spi_rx,
  output logic          spi_sel,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_data,
  output logic          cpu_reset,
  output logic          boot_done,
  output logic [31:0]   jump_addr
);

  logic          go, busy, fin, byte_en, clear, at_end, insane;
  logic [7:0]    tx_byte, rx_byte;
  logic [AW-1:0] count_q;

  spi_xfer_ctl #(.DW(8)) u_xfer (
    .clk(clk), .rst_n(rst_n), .go(go), .tx_in(tx_byte),
    .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx),
    .busy(busy), .fin(fin), .rx_out(rx_byte)
  );

  size_tracker #(.CW(AW), .SANITY_EN(SANITY_EN), .MAX_HI(MAX_HI)) u_size (
    .clk(clk), .rst_n(rst_n), .clear(clear), .byte_en(byte_en), .byte_in(rx_byte),
    .count_q(count_q), .at_end(at_end), .insane(insane)
  );

  boot_fsm #(
    .AW(AW), .ADR_HI(ADR_HI), .ADR_MID(ADR_MID), .ADR_LO(ADR_LO), .DUMMY(DUMMY),
    .RAM_BASE(RAM_BASE), .RESET_OFS(RESET_OFS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .busy(busy), .fin(fin), .rx_byte(rx_byte),
    .count_q(count_q), .at_end(at_end), .insane(insane), .go(go), .tx_byte(tx_byte),
    .byte_en(byte_en), .clear(clear), .spi_sel(spi_sel), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_data(ram_data), .boot_done(boot_done), .jump_addr(jump_addr)
  );

  assign cpu_reset = !boot_done;

  AST_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> cpu_reset && jump_addr == 32'h0); // R1

endmodule

// File: tb/spi_boot_loader_tb.sv
module spi_boot_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_start, spi_sel, ram_we, cpu_reset, boot_done;
  logic [7:0]  spi_tx, ram_data;
  logic        spi_done = 1'b0;
  logic [7:0]  spi_rx = 8'h00;
  logic [31:0] ram_addr, jump_addr;

  always #2.5 clk = ~clk;

  spi_boot_loader u_dut (
    .clk(clk), .rst_n(rst_n), .spi_start(spi_start), .spi_tx(spi_tx),
    .spi_done(spi_done), .spi_rx(spi_rx), .spi_sel(spi_sel), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_data(ram_data), .cpu_reset(cpu_reset),
    .boot_done(boot_done), .jump_addr(jump_addr)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // flash and RAM model state
  logic [31:0] cur_size = 32'd12;
  bit          retry_mode = 1'b0;
  logic [7:0]  tx_log [0:127];
  logic [7:0]  ram [0:255];
  int n_xfer, attempts, n_wr, bad_wr_addr, sel_viol, delay;
  bit prev_sel, xfer_open;
  logic [7:0] pend_byte;

  function automatic logic [7:0] image_byte(input int d, input int att, input bit rm,
                                            input logic [31:0] sz);
    logic [31:0] hdr;
    hdr = (rm && att == 1) ? 32'h0201_0000 : sz;
    if (d < 4) return hdr[31 - 8*d -: 8];
    return 8'hA0 ^ 8'(d);
  endfunction

  always @(negedge clk) begin
    spi_done <= 1'b0;
    if (!rst_n) begin
      n_xfer <= 0; attempts <= 0; n_wr <= 0; bad_wr_addr <= 0; sel_viol <= 0;
      delay <= 0; prev_sel <= 1'b0; xfer_open <= 1'b0;
    end else begin
      prev_sel <= spi_sel;
      if (spi_sel && !prev_sel) begin
        attempts <= attempts + 1;
        n_xfer <= 0;
      end
      if (spi_start) begin
        if (!spi_sel || xfer_open) sel_viol <= sel_viol + 1;
        if (n_xfer < 128) tx_log[n_xfer] <= spi_tx;
        pend_byte <= (n_xfer < 4) ? 8'hFF : image_byte(n_xfer - 4, attempts, retry_mode, cur_size);
        n_xfer <= n_xfer + 1;
        delay <= 3;
        xfer_open <= 1'b1;
      end else if (xfer_open) begin
        if (delay == 1) begin
          spi_done <= 1'b1;
          spi_rx <= pend_byte;
          xfer_open <= 1'b0;
        end
        delay <= delay - 1;
      end
      if (ram_we) begin
        if (!spi_sel) sel_viol <= sel_viol + 1;
        if (ram_addr < 256) ram[ram_addr[7:0]] <= ram_data;
        else bad_wr_addr <= bad_wr_addr + 1;
        n_wr <= n_wr + 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cpu_reset == 1'b1, "R1 cpu_reset in reset", cpu_reset, 1);
    chk(boot_done == 1'b0, "R1 boot_done in reset", boot_done, 0);
    chk(jump_addr == 32'h0, "R1 jump_addr in reset", jump_addr, 0);
    chk(spi_sel == 1'b0, "R2 select low in reset", spi_sel, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!boot_done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(boot_done == 1'b1, "R9 boot completes", boot_done, 1);
  endtask

  task automatic check_attempt(input logic [31:0] sz, input int extra_wr, input int exp_att);
    int eff;
    eff = (sz < 4) ? 4 : int'(sz);
    chk(tx_log[0] == 8'h03, "R3 opcode", tx_log[0], 8'h03);
    chk(tx_log[1] == 8'h0C && tx_log[2] == 8'h00 && tx_log[3] == 8'h00, "R4 address bytes",
        {tx_log[1], tx_log[2], tx_log[3]}, 24'h0C0000);
    for (int i = 4; i < 4 + eff; i++)
      if (tx_log[i] != 8'h00) chk(1'b0, "R5 dummy byte", tx_log[i], 0);
    chk(1'b1, "R5 dummy bytes scanned", 0, 0);
    chk(sel_viol == 0, "R2/R5 start or write outside select or overlapping", sel_viol, 0);
    chk(n_xfer == 4 + eff, (sz <= 4) ? "R8 exchange count small size" : "R7 exchange count",
        n_xfer, 4 + eff);
    chk(n_wr == eff + extra_wr, "R6 write count", n_wr, eff + extra_wr);
    chk(bad_wr_addr == 0, "R6 write address range", bad_wr_addr, 0);
    for (int d = 0; d < eff; d++)
      if (ram[d] != image_byte(d, exp_att, retry_mode, sz))
        chk(1'b0, "R6 RAM content", ram[d], image_byte(d, exp_att, retry_mode, sz));
    chk(1'b1, "R6 RAM content scanned", 0, 0);
    chk(attempts == exp_att, "R10 attempt count", attempts, exp_att);
    chk(jump_addr == 32'h100, "R9 jump address", jump_addr, 32'h100);
    chk(!spi_sel && !cpu_reset, "R9 deselect and release", {spi_sel, cpu_reset}, 0);
    repeat (40) @(negedge clk);
    chk(boot_done && n_xfer == 4 + eff && jump_addr == 32'h100, "R9 holds after done",
        n_xfer, 4 + eff);
  endtask

  task automatic test_boot(input logic [31:0] sz);
    cur_size = sz;
    retry_mode = 1'b0;
    for (int i = 0; i < 256; i++) ram[i] = 8'h55;
    apply_reset();
    repeat (2) @(negedge clk);
    chk(n_wr == 0, "R1 no write after reset before data", n_wr, 0);
    wait_done();
    check_attempt(sz, 0, 1);
  endtask

  task automatic test_retry(input logic [31:0] sz);
    cur_size = sz;
    retry_mode = 1'b1;
    apply_reset();
    wait_done();
    check_attempt(sz, 4, 2);
  endtask

  initial begin
    test_boot(32'd12);
    test_boot(32'd4);
    test_boot(32'd2);
    test_boot(32'd37);
    test_retry(32'd9);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule